// File: doc/BRIEF.md
# SPI Register-Access Slave

This block lets an external SPI master read and write a small bank of 8-bit registers through four wires: an active-low chip enable, a serial clock, serial data in and serial data out. The serial pins are oversampled by the block's own system clock. The serial clock is treated as a data signal, and the whole block runs in a single clock domain. The system clock should run at least twelve times faster than the serial clock.

A transaction opens when chip enable goes low. The first byte is a command. It carries the direction, a two-bit subaddress that must match the block's identity, and the start register. Each following byte is written into the register bank, or read out of it, at the current address. The address then steps forward by one and wraps to zero past the last register. Raising chip enable ends the transaction at any point and throws away any incomplete byte.

Top module: `spi_regif`

## Requirements
- R1: While the synchronized chip enable is high, the bit counter and shift state are cleared and `sdo_o` is 0. A transaction cut off mid-byte leaves no trace, and the next transaction decodes its first byte as a command.
- R2: All bytes move most significant bit first. `sdi_i` is sampled on rising serial clock edges.
- R3: Command byte layout: bit 7 is the direction (1 = read, 0 = write), bits 6:5 are the subaddress, and bits 4:0 are the start register address.
- R4: When the command subaddress differs from 2'b01, the rest of the transaction is ignored. No register is written and `sdo_o` stays 0.
- R5: A data byte is written only after all eight of its bits have been received. A partial byte ended by chip enable rising changes nothing.
- R6: After each data byte, read or write, the register address increases by one.
- R7: In a read, the addressed register's MSB appears on `sdo_o` after the first falling serial clock edge that follows the command's last rising edge. `sdo_o` changes only after falling serial clock edges or on chip enable release.
- R8: The bank holds 28 registers (0x00 to 0x1B). In both directions the address wraps from 0x1B to 0x00.
- R9: The direction set by the command holds for the whole transaction. Data shifted in during a read never writes a register.
- R10: After reset, every register reads 0x00 and `sdo_o` is 0.
- R11: Addresses 0x1C to 0x1F hold no register. Writes to them are dropped, reads return 0x00, and the address that follows them is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip enable, active low |
| sclk_i | input | 1 | Serial clock from the master, idle low |
| sdi_i | input | 1 | Serial data from the master |
| sdo_o | output | 1 | Serial data to the master |

## Verification
At the end of each data byte, two events land in the same system cycle: the address steps forward, and the next register is fetched into the output shifter. Where a burst crosses 0x1B, the wrap to zero coincides with both of them. Bursts that write from 0x1B and read from 0x1A provoke this case. The test passes only if the byte shifted out after 0x1B is register 0x00 and the byte written after 0x1B lands in register 0x00. A second burst starting at the hole address 0x1D judges the same wrap decision without any register write at the start address.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;
  localparam int BCNT_W = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    ST_CMD = 2'd0,
    ST_WR  = 2'd1,
    ST_RD  = 2'd2,
    ST_IGN = 2'd3
  } regif_state_e;

  typedef struct packed {
    logic              rd;
    logic [1:0]        sub;
    logic [ADDR_W-1:0] addr;
  } regif_cmd_t;
endpackage

// File: rtl/spi_regif_sync.sv
module spi_regif_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= RST_VAL;
        else         stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_regif_shift.sv
module spi_regif_shift
  import spi_regif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdi_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_data_i,
  input  logic              tx_en_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic [BCNT_W-1:0] bit_cnt_o,
  output logic              sdo_o
);
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BYTE_W - 1);

  logic [BCNT_W-1:0] bit_cnt_q;
  logic [BYTE_W-2:0] rx_q;
  logic [BYTE_W-1:0] tx_q;
  logic              sdo_q;

  // byte completes on the eighth rising edge; last bit taken straight from the pin
  assign byte_done_o = rise_i && (bit_cnt_q == LAST_BIT);
  assign rx_byte_o   = {rx_q, sdi_i};
  assign bit_cnt_o   = bit_cnt_q;
  assign sdo_o       = sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      sdo_q     <= 1'b0;
    end else if (!active_i) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      sdo_q     <= 1'b0;
    end else begin
      if (rise_i) begin
        bit_cnt_q <= bit_cnt_q + 1'b1;
        rx_q      <= {rx_q[BYTE_W-3:0], sdi_i};
      end
      if (load_i) begin
        tx_q <= load_data_i;
      end else if (fall_i) begin
        tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
      end
      if (fall_i) begin
        sdo_q <= tx_en_i ? tx_q[BYTE_W-1] : 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_regif_ctrl.sv
module spi_regif_ctrl
  import spi_regif_pkg::*;
#(
  parameter int         NUM_REGS = 28,
  parameter logic [1:0] SUB_ID   = 2'b01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output regif_state_e      state_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              load_o,
  output logic              tx_en_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

  regif_state_e      state_q;
  logic [ADDR_W-1:0] addr_q;
  regif_cmd_t        cmd;
  logic              cmd_ok;
  logic [ADDR_W-1:0] addr_nxt;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return (a >= LAST_ADDR) ? '0 : a + 1'b1;
  endfunction

  assign cmd      = regif_cmd_t'(rx_byte_i);
  assign cmd_ok   = (cmd.sub == SUB_ID);
  assign addr_nxt = step_addr(addr_q);

  always_comb begin
    wr_en_o   = byte_done_i && (state_q == ST_WR);
    wr_addr_o = addr_q;
    wr_data_o = rx_byte_i;
    rd_addr_o = (state_q == ST_CMD) ? cmd.addr : addr_nxt;
    load_o    = byte_done_i &&
                (((state_q == ST_CMD) && cmd_ok && cmd.rd) || (state_q == ST_RD));
    tx_en_o   = (state_q == ST_RD);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;
      addr_q  <= '0;
    end else if (!active_i) begin
      state_q <= ST_CMD;
      addr_q  <= '0;
    end else if (byte_done_i) begin
      unique case (state_q)
        ST_CMD: begin
          if (cmd_ok) begin
            state_q <= cmd.rd ? ST_RD : ST_WR;
            addr_q  <= cmd.addr;
          end else begin
            state_q <= ST_IGN;
          end
        end
        ST_WR, ST_RD: addr_q <= addr_nxt;
        default: ;
      endcase
    end
  end

  assign state_o = state_q;
  assign addr_o  = addr_q;
endmodule

// File: rtl/spi_regif_regbank.sv
module spi_regif_regbank
  import spi_regif_pkg::*;
#(
  parameter int                NUM_REGS = 28,
  parameter logic [BYTE_W-1:0] RST_VAL  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [BYTE_W-1:0] reg_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        reg_q[i] <= RST_VAL;
      end else if (wr_en_i && (wr_addr_i == ADDR_W'(i))) begin
        reg_q[i] <= wr_data_i;
      end
    end
  end

  // addresses without a register decode to zero
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr_i == ADDR_W'(i)) rd_data_o = reg_q[i];
    end
  end
endmodule

// File: rtl/spi_regif.sv
module spi_regif
  import spi_regif_pkg::*;
#(
  parameter int         NUM_REGS    = 28,
  parameter logic [1:0] SUB_ID      = 2'b01,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o
);
  logic [2:0]        pin_s;
  logic              cs_s, sclk_s, sdi_s;
  logic              sclk_d_q;
  logic              active, sclk_rise, sclk_fall;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte;
  logic [BCNT_W-1:0] bit_cnt;
  regif_state_e      state;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic              load, tx_en;

  spi_regif_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdi_i}),
    .q_o   (pin_s)
  );

  assign cs_s   = pin_s[2];
  assign sclk_s = pin_s[1];
  assign sdi_s  = pin_s[0];
  assign active = ~cs_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= sclk_s;
  end

  assign sclk_rise = active &  sclk_s & ~sclk_d_q;
  assign sclk_fall = active & ~sclk_s &  sclk_d_q;

  spi_regif_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .rise_i     (sclk_rise),
    .fall_i     (sclk_fall),
    .sdi_i      (sdi_s),
    .load_i     (load),
    .load_data_i(rd_data),
    .tx_en_i    (tx_en),
    .byte_done_o(byte_done),
    .rx_byte_o  (rx_byte),
    .bit_cnt_o  (bit_cnt),
    .sdo_o      (sdo_o)
  );

  spi_regif_ctrl #(
    .NUM_REGS(NUM_REGS),
    .SUB_ID  (SUB_ID)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .byte_done_i(byte_done),
    .rx_byte_i  (rx_byte),
    .state_o    (state),
    .addr_o     (addr_q),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .rd_addr_o  (rd_addr),
    .load_o     (load),
    .tx_en_o    (tx_en)
  );

  spi_regif_regbank #(
    .NUM_REGS(NUM_REGS)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );
endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk
  import spi_regif_pkg::*;
#(
  parameter int NUM_REGS = 28
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              active_i,
  input logic              rise_i,
  input logic              fall_i,
  input logic              sdo_i,
  input logic [BCNT_W-1:0] bit_cnt_i,
  input logic              byte_done_i,
  input logic              wr_en_i,
  input regif_state_e      state_i,
  input logic [ADDR_W-1:0] addr_i
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

  logic step;
  assign step = byte_done_i && ((state_i == ST_WR) || (state_i == ST_RD));

  AST_IDLE_SDO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !sdo_i); // R1
  AST_IDLE_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (bit_cnt_i == '0)); // R1
  AST_SDO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_i) |-> ($past(fall_i) || $past(!active_i))); // R7
  AST_WR_FULL_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (rise_i && (bit_cnt_i == BCNT_W'(BYTE_W - 1)) && (state_i == ST_WR))); // R5
  AST_NO_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IGN) |-> !wr_en_i); // R4
  AST_NO_WR_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RD) |-> !wr_en_i); // R9
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && (addr_i < LAST_ADDR)) |=> (addr_i == $past(addr_i) + 1'b1)); // R6
  AST_ADDR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && (addr_i >= LAST_ADDR)) |=> (addr_i == '0)); // R8
endmodule

bind spi_regif spi_regif_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .active_i   (active),
  .rise_i     (sclk_rise),
  .fall_i     (sclk_fall),
  .sdo_i      (sdo_o),
  .bit_cnt_i  (bit_cnt),
  .byte_done_i(byte_done),
  .wr_en_i    (wr_en),
  .state_i    (state),
  .addr_i     (addr_q)
);

// File: tb/spi_regif_tb.sv
module spi_regif_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int WATCHDOG   = 100000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1;
  logic sclk_i = 1'b0;
  logic sdi_i = 1'b0;
  logic sdo_o;

  int n_checks = 0;
  int n_fail   = 0;
  int glitches = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spi_regif u_dut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cs_ni (cs_ni),
    .sclk_i(sclk_i),
    .sdi_i (sdi_i),
    .sdo_o (sdo_o)
  );

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic cs_open();
    cs_ni = 1'b0;
    wait_clks(4);
  endtask

  task automatic cs_close();
    wait_clks(4);
    cs_ni = 1'b1;
    wait_clks(6);
  endtask

  // shifts nbits of tx, MSB first; returns bits seen on sdo before each rising edge
  task automatic shift_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    logic hi;
    rx = '0;
    for (int k = 0; k < nbits; k++) begin
      sdi_i = tx[7-k];
      wait_clks(HALF);
      rx[7-k] = sdo_o;
      sclk_i = 1'b1;
      wait_clks(1);
      hi = sdo_o;
      wait_clks(HALF - 1);
      if (sdo_o !== hi) glitches++;
      sclk_i = 1'b0;
    end
  endtask

  task automatic write_burst(input logic [4:0] addr, input logic [7:0] d0,
                             input logic [7:0] d1, input int n);
    logic [7:0] rx;
    cs_open();
    shift_bits({3'b001, addr}, 8, rx);
    shift_bits(d0, 8, rx);
    if (n > 1) shift_bits(d1, 8, rx);
    cs_close();
  endtask

  task automatic read_one(input logic [4:0] addr, output logic [7:0] v);
    logic [7:0] rx;
    cs_open();
    shift_bits({3'b101, addr}, 8, rx);
    shift_bits(8'h00, 8, v);
    cs_close();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check8("R10 sdo after reset", {7'b0, sdo_o}, 8'h00);
    read_one(5'h00, v);
    check8("R10 reg 0x00 reset", v, 8'h00);
    read_one(5'h1B, v);
    check8("R10 reg 0x1B reset", v, 8'h00);
  endtask

  task automatic t_write_burst();
    logic [7:0] rx, b0, b1, b2, b3;
    cs_open();
    shift_bits(8'h20, 8, rx);
    shift_bits(8'hA5, 8, rx);
    shift_bits(8'h3C, 8, rx);
    shift_bits(8'h81, 8, rx);
    shift_bits(8'h7E, 8, rx);
    cs_close();
    cs_open();
    shift_bits(8'hA0, 8, rx);
    shift_bits(8'h00, 8, b0);
    shift_bits(8'h00, 8, b1);
    shift_bits(8'h00, 8, b2);
    shift_bits(8'h00, 8, b3);
    cs_close();
    check8("R7 first read byte", b0, 8'hA5);
    check8("R2 msb first 0x3C", b1, 8'h3C);
    check8("R6 increment to 0x02", b2, 8'h81);
    check8("R6 increment to 0x03", b3, 8'h7E);
    read_one(5'h02, rx);
    check8("R3 start address field", rx, 8'h81);
  endtask

  task automatic t_wrap();
    logic [7:0] rx, b0, b1, b2;
    write_burst(5'h1B, 8'h11, 8'h22, 2);
    cs_open();
    shift_bits(8'hBA, 8, rx);
    shift_bits(8'h00, 8, b0);
    shift_bits(8'h00, 8, b1);
    shift_bits(8'h00, 8, b2);
    cs_close();
    check8("R8 read 0x1A", b0, 8'h00);
    check8("R8 read 0x1B", b1, 8'h11);
    check8("R8 read wraps to 0x00", b2, 8'h22);
  endtask

  task automatic t_bad_sub();
    logic [7:0] rx, b0, b1;
    cs_open();
    shift_bits(8'h41, 8, rx);
    shift_bits(8'hFF, 8, rx);
    cs_close();
    read_one(5'h01, rx);
    check8("R4 write with bad subaddress", rx, 8'h3C);
    cs_open();
    shift_bits(8'hC1, 8, rx);
    shift_bits(8'h00, 8, b0);
    shift_bits(8'h00, 8, b1);
    cs_close();
    check8("R4 read with bad subaddress byte0", b0, 8'h00);
    check8("R4 read with bad subaddress byte1", b1, 8'h00);
  endtask

  task automatic t_partial();
    logic [7:0] rx;
    cs_open();
    shift_bits(8'h22, 8, rx);
    shift_bits(8'hFF, 5, rx);
    cs_close();
    read_one(5'h02, rx);
    check8("R5 partial byte dropped", rx, 8'h81);
    cs_open();
    shift_bits(8'h23, 8, rx);
    shift_bits(8'h99, 8, rx);
    shift_bits(8'hFF, 3, rx);
    cs_close();
    read_one(5'h03, rx);
    check8("R5 full byte written", rx, 8'h99);
    read_one(5'h04, rx);
    check8("R5 trailing partial byte dropped", rx, 8'h00);
  endtask

  task automatic t_cs_abort();
    logic [7:0] rx;
    cs_open();
    shift_bits(8'hFF, 3, rx);
    cs_close();
    read_one(5'h01, rx);
    check8("R1 aborted command discarded", rx, 8'h3C);
    cs_open();
    shift_bits(8'hA0, 8, rx);
    shift_bits(8'h00, 3, rx);
    cs_close();
    check8("R1 sdo low after abort", {7'b0, sdo_o}, 8'h00);
  endtask

  task automatic t_read_fixed();
    logic [7:0] rx, b0, b1;
    cs_open();
    shift_bits(8'hA0, 8, rx);
    shift_bits(8'hFF, 8, b0);
    shift_bits(8'hFF, 8, b1);
    cs_close();
    check8("R9 read byte0", b0, 8'h22);
    check8("R9 read byte1", b1, 8'h3C);
    read_one(5'h00, rx);
    check8("R9 reg 0x00 not written by read", rx, 8'h22);
    read_one(5'h01, rx);
    check8("R9 reg 0x01 not written by read", rx, 8'h3C);
  endtask

  task automatic t_hole();
    logic [7:0] rx, b0, b1;
    write_burst(5'h1D, 8'h55, 8'h66, 2);
    read_one(5'h00, rx);
    check8("R11 write after hole goes to 0x00", rx, 8'h66);
    cs_open();
    shift_bits(8'hBD, 8, rx);
    shift_bits(8'h00, 8, b0);
    shift_bits(8'h00, 8, b1);
    cs_close();
    check8("R11 hole reads zero", b0, 8'h00);
    check8("R11 address after hole is 0x00", b1, 8'h66);
  endtask

  initial begin
    wait_clks(3);
    rst_ni = 1'b1;
    wait_clks(3);
    t_reset();
    t_write_burst();
    t_wrap();
    t_bad_sub();
    t_partial();
    t_cs_abort();
    t_read_fixed();
    t_hole();
    check8("R7 sdo steady while sclk high", glitches[7:0], 8'h00);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule